// File: doc/BRIEF.md
# Parallel Address Translation and Line Lookup Unit

This block resolves one memory access per cycle. A 32-bit virtual address and an access type (read or write) enter. In the same cycle the block reads two tables side by side. One is a 64-entry direct-mapped translation table. The other is a 64-line direct-mapped data cache with 16-byte lines. The cache is indexed with address bits that lie inside the page offset, so it needs no translation first. The physical tag stored with each line is compared with the frame number that the translation table returns.

The outcome is one of three. A hit returns the addressed byte on a read, or stores the supplied byte on a write at the next clock edge. A fault means the translation is missing or the access is not permitted. A plain miss means the translation is good but the line is absent or belongs to another frame. Two fill ports load translation entries and cache lines. Walking the page table, fetching lines from memory and writing lines back all sit outside this block.

Top module: `vipt_lookup`

## Requirements
- R1: Address fields: bits 3-0 select the byte within the line, bits 9-4 select the cache line, bits 15-10 select the translation entry, and bits 31-16 are compared with that entry's tag. For address 0x1234ABCD the fields are byte 0xD, line 0x3C, entry 0x2A and tag 0x1234.
- R2: When `tlb_fill_en` is high, the entry at `tlb_fill_idx` takes the supplied valid bit, 16-bit tag, 22-bit frame number and the read and write permission bits at the next clock edge. Lookups from the following cycle on use the new entry.
- R3: `rsp_hit` is high only when all five conditions hold: the entry is valid, its tag equals address bits 31-16, it permits the access type, the line is valid, and the line's 22-bit physical tag equals the entry's frame number.
- R4: If `req_valid` is high and the entry is invalid or its tag differs from bits 31-16, `rsp_fault` is high and `rsp_hit` is low.
- R5: A read (`req_write`=0) needs the entry's read permission and a write (`req_write`=1) needs its write permission. Without the needed permission the access faults, even if the tag matches.
- R6: If the translation succeeds and is permitted, but the line is invalid or its physical tag differs from the frame number, both `rsp_hit` and `rsp_fault` are low.
- R7: On a read hit, `rsp_rdata` carries line byte k, which is held at bits 8k+7..8k of the line, where k is address bits 3-0. In every other case `rsp_rdata` is 0.
- R8: On a write hit, only byte k of the line takes `req_wdata`, at the clock edge. The other 15 bytes, the valid bit and the physical tag stay as they were.
- R9: A write that faults or misses leaves every line unchanged.
- R10: A synchronous active-high `rst` clears every valid bit in both tables, so that any request after reset faults.
- R11: When `line_fill_en` is high, line `line_fill_idx` takes the supplied valid bit, physical tag and 128-bit data at the next edge. If a write hit targets the same line in the same cycle, the fill wins and the write is dropped.
- R12: When `req_valid` is low, `rsp_hit`, `rsp_fault` and `rsp_rdata` are all 0, and no line is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_wdata | input | 8 | Byte stored on a write hit |
| rsp_hit | output | 1 | Access hit in both tables with permission |
| rsp_fault | output | 1 | Translation missing or access not permitted |
| rsp_rdata | output | 8 | Addressed byte on a read hit, otherwise 0 |
| tlb_fill_en | input | 1 | Load one translation entry |
| tlb_fill_idx | input | 6 | Entry to load |
| tlb_fill_valid | input | 1 | Valid bit for the loaded entry |
| tlb_fill_tag | input | 16 | Virtual tag for the loaded entry |
| tlb_fill_pfn | input | 22 | Physical frame number for the loaded entry |
| tlb_fill_rd | input | 1 | Read permission |
| tlb_fill_wr | input | 1 | Write permission |
| line_fill_en | input | 1 | Load one cache line |
| line_fill_idx | input | 6 | Line to load |
| line_fill_valid | input | 1 | Valid bit for the loaded line |
| line_fill_ptag | input | 22 | Physical tag for the loaded line |
| line_fill_data | input | 128 | Line data, byte k at bits 8k+7..8k |

## Verification
The bench targets the case where the translation succeeds but the line holds a different frame. A design that compared the line tag with the virtual page number, or left out that comparison, would report a false hit. It sends writes to read-only entries and then reads the line back. A design that let a faulting write reach the array would change a byte that must stay fixed. It writes single bytes and then reads all sixteen, which exposes a lane decode that touches neighbouring bytes. It also collides a line fill with a write hit to the same line; if the write won, the stale byte would survive over the fill.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    localparam int VA_W       = 32;
    localparam int BYTE_W     = 8;
    localparam int PAGE_OFF_W = 10;
    localparam int LINE_OFF_W = 4;
    localparam int LINE_IDX_W = 6;
    localparam int TLB_IDX_W  = 6;
    localparam int PFN_W      = 22;

    localparam int TLB_TAG_W  = VA_W - PAGE_OFF_W - TLB_IDX_W;
    localparam int LINE_BYTES = 1 << LINE_OFF_W;
    localparam int LINE_W     = LINE_BYTES * BYTE_W;
    localparam int TLB_DEPTH  = 1 << TLB_IDX_W;
    localparam int LINE_DEPTH = 1 << LINE_IDX_W;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } access_e;

    typedef struct packed {
        logic [TLB_TAG_W-1:0] tag;
        logic [PFN_W-1:0]     pfn;
        logic                 rd_ok;
        logic                 wr_ok;
    } tlb_entry_t;

    // Field order follows the address bit order, most significant first.
    typedef struct packed {
        logic [TLB_TAG_W-1:0]  tlb_tag;
        logic [TLB_IDX_W-1:0]  tlb_idx;
        logic [LINE_IDX_W-1:0] line_idx;
        logic [LINE_OFF_W-1:0] byte_off;
    } va_fields_t;

    function automatic va_fields_t split_va(logic [VA_W-1:0] va);
        return va_fields_t'(va);
    endfunction

    function automatic logic access_allowed(tlb_entry_t e, access_e a);
        return (a == ACC_WRITE) ? e.wr_ok : e.rd_ok;
    endfunction

endpackage

// File: rtl/vtlb_tlb_bank.sv
module vtlb_tlb_bank
    import vtlb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TLB_IDX_W-1:0] rd_idx,
    output logic                 rd_valid,
    output tlb_entry_t           rd_entry,
    input  logic                 fill_en,
    input  logic [TLB_IDX_W-1:0] fill_idx,
    input  logic                 fill_valid,
    input  tlb_entry_t           fill_entry
);

    logic [TLB_DEPTH-1:0] valid_q;
    tlb_entry_t           entry_q [TLB_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx] <= fill_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            entry_q[fill_idx] <= fill_entry;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_entry = entry_q[rd_idx];

    // R10: reset leaves no translation valid
    assert_tlb_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (valid_q == '0));

    // R2: a fill lands its valid bit in the addressed entry
    assert_tlb_fill_lands_R2: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (valid_q[$past(fill_idx)] == $past(fill_valid)));

endmodule

// File: rtl/vtlb_line_bank.sv
module vtlb_line_bank
    import vtlb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LINE_IDX_W-1:0] acc_idx,
    input  logic [LINE_OFF_W-1:0] acc_off,
    output logic                  rd_valid,
    output logic [PFN_W-1:0]      rd_ptag,
    output logic [BYTE_W-1:0]     rd_byte,
    input  logic                  wr_en,
    input  logic [BYTE_W-1:0]     wr_byte,
    input  logic                  fill_en,
    input  logic [LINE_IDX_W-1:0] fill_idx,
    input  logic                  fill_valid,
    input  logic [PFN_W-1:0]      fill_ptag,
    input  logic [LINE_W-1:0]     fill_data
);

    logic [LINE_DEPTH-1:0] valid_q;
    logic [PFN_W-1:0]      ptag_q [LINE_DEPTH];
    logic [BYTE_W-1:0]     lane_rd [LINE_BYTES];
    logic [LINE_BYTES-1:0] lane_we;
    logic                  fill_collides;

    // A fill to the line being written wins over the byte write.
    assign fill_collides = fill_en && (fill_idx == acc_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx] <= fill_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            ptag_q[fill_idx] <= fill_ptag;
        end
    end

    for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [LINE_DEPTH];

        assign lane_we[k] = wr_en && !fill_collides && (acc_off == LINE_OFF_W'(k));

        always_ff @(posedge clk) begin
            if (fill_en) begin
                lane_mem[fill_idx] <= fill_data[k*BYTE_W +: BYTE_W];
            end
            if (lane_we[k]) begin
                lane_mem[acc_idx] <= wr_byte;
            end
        end

        assign lane_rd[k] = lane_mem[acc_idx];
    end

    assign rd_valid = valid_q[acc_idx];
    assign rd_ptag  = ptag_q[acc_idx];
    assign rd_byte  = lane_rd[acc_off];

    // R8: a write touches at most one byte lane
    assert_single_lane_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lane_we));

    // R10: reset leaves no line valid
    assert_line_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (valid_q == '0));

endmodule

// File: rtl/vtlb_judge.sv
module vtlb_judge
    import vtlb_pkg::*;
(
    input  logic                 req_valid,
    input  access_e              acc,
    input  logic [TLB_TAG_W-1:0] va_tag,
    input  logic                 tlb_valid,
    input  tlb_entry_t           tlb_entry,
    input  logic                 line_valid,
    input  logic [PFN_W-1:0]     line_ptag,
    input  logic [BYTE_W-1:0]    line_byte,
    output logic                 hit,
    output logic                 fault,
    output logic                 line_wr,
    output logic [BYTE_W-1:0]    rdata
);

    logic xlate_ok;
    logic perm_ok;
    logic line_ok;

    always_comb begin
        xlate_ok = tlb_valid && (tlb_entry.tag == va_tag);
        perm_ok  = access_allowed(tlb_entry, acc);
        line_ok  = line_valid && (line_ptag == tlb_entry.pfn);
        fault    = req_valid && !(xlate_ok && perm_ok);
        hit      = req_valid && xlate_ok && perm_ok && line_ok;
        line_wr  = hit && (acc == ACC_WRITE);
        rdata    = (hit && (acc == ACC_READ)) ? line_byte : '0;
    end

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vtlb_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic [31:0]  req_va,
    input  logic         req_write,
    input  logic [7:0]   req_wdata,
    output logic         rsp_hit,
    output logic         rsp_fault,
    output logic [7:0]   rsp_rdata,
    input  logic         tlb_fill_en,
    input  logic [5:0]   tlb_fill_idx,
    input  logic         tlb_fill_valid,
    input  logic [15:0]  tlb_fill_tag,
    input  logic [21:0]  tlb_fill_pfn,
    input  logic         tlb_fill_rd,
    input  logic         tlb_fill_wr,
    input  logic         line_fill_en,
    input  logic [5:0]   line_fill_idx,
    input  logic         line_fill_valid,
    input  logic [21:0]  line_fill_ptag,
    input  logic [127:0] line_fill_data
);

    va_fields_t        va;
    access_e           acc;
    tlb_entry_t        tlb_rd;
    tlb_entry_t        tlb_new;
    logic              tlb_rd_valid;
    logic              line_rd_valid;
    logic [PFN_W-1:0]  line_rd_ptag;
    logic [BYTE_W-1:0] line_rd_byte;
    logic              line_wr;

    assign va  = split_va(req_va);
    assign acc = access_e'(req_write);

    assign tlb_new = '{tag: tlb_fill_tag, pfn: tlb_fill_pfn,
                       rd_ok: tlb_fill_rd, wr_ok: tlb_fill_wr};

    vtlb_tlb_bank u_tlb (
        .clk        (clk),
        .rst        (rst),
        .rd_idx     (va.tlb_idx),
        .rd_valid   (tlb_rd_valid),
        .rd_entry   (tlb_rd),
        .fill_en    (tlb_fill_en),
        .fill_idx   (tlb_fill_idx),
        .fill_valid (tlb_fill_valid),
        .fill_entry (tlb_new)
    );

    vtlb_line_bank u_lines (
        .clk        (clk),
        .rst        (rst),
        .acc_idx    (va.line_idx),
        .acc_off    (va.byte_off),
        .rd_valid   (line_rd_valid),
        .rd_ptag    (line_rd_ptag),
        .rd_byte    (line_rd_byte),
        .wr_en      (line_wr),
        .wr_byte    (req_wdata),
        .fill_en    (line_fill_en),
        .fill_idx   (line_fill_idx),
        .fill_valid (line_fill_valid),
        .fill_ptag  (line_fill_ptag),
        .fill_data  (line_fill_data)
    );

    vtlb_judge u_judge (
        .req_valid  (req_valid),
        .acc        (acc),
        .va_tag     (va.tlb_tag),
        .tlb_valid  (tlb_rd_valid),
        .tlb_entry  (tlb_rd),
        .line_valid (line_rd_valid),
        .line_ptag  (line_rd_ptag),
        .line_byte  (line_rd_byte),
        .hit        (rsp_hit),
        .fault      (rsp_fault),
        .line_wr    (line_wr),
        .rdata      (rsp_rdata)
    );

    // R4: hit and fault never appear together
    assert_hit_fault_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && rsp_fault));

    // R9: a faulting request never reaches the line store
    assert_fault_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> !line_wr);

    // R12: an idle cycle is silent
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!rsp_hit && !rsp_fault && (rsp_rdata == 8'h00) && !line_wr));

    // R7: read data is zero unless the access hit
    assert_rdata_needs_hit_R7: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_rdata == 8'h00));

endmodule

// File: tb/test_vipt_lookup.sv
module test_vipt_lookup;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [31:0]  req_va;
    logic         req_write;
    logic [7:0]   req_wdata;
    logic         rsp_hit;
    logic         rsp_fault;
    logic [7:0]   rsp_rdata;
    logic         tlb_fill_en;
    logic [5:0]   tlb_fill_idx;
    logic         tlb_fill_valid;
    logic [15:0]  tlb_fill_tag;
    logic [21:0]  tlb_fill_pfn;
    logic         tlb_fill_rd;
    logic         tlb_fill_wr;
    logic         line_fill_en;
    logic [5:0]   line_fill_idx;
    logic         line_fill_valid;
    logic [21:0]  line_fill_ptag;
    logic [127:0] line_fill_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    vipt_lookup i_vipt_lookup (.*);

    int tests_run    = 0;
    int tests_failed = 0;

    // Reference state, kept as plain behavioural tables.
    bit        m_tv   [64];
    bit [15:0] m_ttag [64];
    bit [21:0] m_tpfn [64];
    bit        m_tr   [64];
    bit        m_tw   [64];
    bit        m_lv   [64];
    bit [21:0] m_lptag[64];
    bit [7:0]  m_data [64][16];

    logic       s_hit, s_fault;
    logic [7:0] s_rdata;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_line(bit [7:0] base);
        logic [127:0] l;
        for (int k = 0; k < 16; k++) l[k*8 +: 8] = base + 8'(k);
        return l;
    endfunction

    task automatic idle_inputs();
        req_valid = 0; req_va = '0; req_write = 0; req_wdata = '0;
        tlb_fill_en = 0; tlb_fill_idx = '0; tlb_fill_valid = 0; tlb_fill_tag = '0;
        tlb_fill_pfn = '0; tlb_fill_rd = 0; tlb_fill_wr = 0;
        line_fill_en = 0; line_fill_idx = '0; line_fill_valid = 0;
        line_fill_ptag = '0; line_fill_data = '0;
    endtask

    // Inputs are set at a falling edge; outputs are sampled 1 time unit later,
    // compared with the model, and the model advances at the rising edge.
    task automatic cycle(string tag);
        bit [5:0] ti, li;
        bit [3:0] bo;
        bit       tok, pok, lok, e_hit, e_fault, e_wr;
        bit [7:0] e_rd;
        #1;
        s_hit = rsp_hit; s_fault = rsp_fault; s_rdata = rsp_rdata;
        ti = req_va[15:10]; li = req_va[9:4]; bo = req_va[3:0];
        tok = m_tv[ti] && (m_ttag[ti] == req_va[31:16]);
        pok = req_write ? m_tw[ti] : m_tr[ti];
        lok = m_lv[li] && (m_lptag[li] == m_tpfn[ti]);
        e_fault = req_valid && !(tok && pok);
        e_hit   = req_valid && tok && pok && lok;
        e_wr    = e_hit && req_write;
        e_rd    = (e_hit && !req_write) ? m_data[li][bo] : 8'h00;
        if (!rst) begin
            check(tag, "hit",   32'(s_hit),   32'(e_hit));
            check(tag, "fault", 32'(s_fault), 32'(e_fault));
            check(tag, "rdata", 32'(s_rdata), 32'(e_rd));
        end
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 64; i++) begin m_tv[i] = 0; m_lv[i] = 0; end
        end else begin
            if (tlb_fill_en) begin
                m_tv[tlb_fill_idx] = tlb_fill_valid; m_ttag[tlb_fill_idx] = tlb_fill_tag;
                m_tpfn[tlb_fill_idx] = tlb_fill_pfn;
                m_tr[tlb_fill_idx] = tlb_fill_rd; m_tw[tlb_fill_idx] = tlb_fill_wr;
            end
            if (e_wr && !(line_fill_en && line_fill_idx == li)) m_data[li][bo] = req_wdata;
            if (line_fill_en) begin
                m_lv[line_fill_idx] = line_fill_valid; m_lptag[line_fill_idx] = line_fill_ptag;
                for (int k = 0; k < 16; k++) m_data[line_fill_idx][k] = line_fill_data[k*8 +: 8];
            end
        end
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic fill_tlb(bit [5:0] idx, bit v, bit [15:0] tg, bit [21:0] pfn, bit r, bit w);
        tlb_fill_en = 1; tlb_fill_idx = idx; tlb_fill_valid = v; tlb_fill_tag = tg;
        tlb_fill_pfn = pfn; tlb_fill_rd = r; tlb_fill_wr = w;
        cycle("R2");
    endtask

    task automatic fill_line(bit [5:0] idx, bit v, bit [21:0] pt, logic [127:0] d);
        line_fill_en = 1; line_fill_idx = idx; line_fill_valid = v;
        line_fill_ptag = pt; line_fill_data = d;
        cycle("R11");
    endtask

    task automatic access(string tag, bit [31:0] va, bit wr, bit [7:0] wd);
        req_valid = 1; req_va = va; req_write = wr; req_wdata = wd;
        cycle(tag);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests_failed++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst = 1;
        @(negedge clk);
        cycle("R10");
        cycle("R10");
        rst = 0;

        // R10: fresh state faults
        access("R10", 32'h1234ABCD, 0, 0);
        check("R10", "fault after reset", 32'(s_fault), 1);
        // R12: idle request is silent
        cycle("R12");
        check("R12", "idle hit", 32'(s_hit), 0);

        fill_tlb(6'h2A, 1, 16'h1234, 22'h0ABCD, 1, 1);
        fill_line(6'h3C, 1, 22'h0ABCD, mk_line(8'hB0));
        // R1 R3 R7: worked address reads byte 0xD of line 0x3C
        access("R1", 32'h1234ABCD, 0, 0);
        check("R1", "hit", 32'(s_hit), 1);
        check("R7", "byte D", 32'(s_rdata), 32'hBD);
        access("R3", 32'h1234ABC0, 0, 0);
        check("R3", "byte 0", 32'(s_rdata), 32'hB0);

        // R4: tag mismatch faults
        access("R4", 32'h1235ABCD, 0, 0);
        check("R4", "fault tag", 32'(s_fault), 1);

        // R6: frame mismatch in line is a quiet miss
        fill_line(6'h3D, 1, 22'h0ABCE, mk_line(8'h10));
        access("R6", 32'h1234ABD4, 0, 0);
        check("R6", "no hit", 32'(s_hit), 0);
        check("R6", "no fault", 32'(s_fault), 0);
        fill_line(6'h3E, 0, 22'h0ABCD, mk_line(8'h20));
        access("R6", 32'h1234ABE0, 0, 0);
        check("R6", "invalid line", 32'(s_hit), 0);

        // R8: write one byte, read all sixteen
        access("R8", 32'h1234ABC5, 1, 8'h5A);
        check("R8", "write hit", 32'(s_hit), 1);
        check("R7", "rdata on write", 32'(s_rdata), 0);
        for (int k = 0; k < 16; k++) begin
            access("R8", 32'h1234ABC0 | k, 0, 0);
            check("R8", "readback", 32'(s_rdata), (k == 5) ? 32'h5A : 32'(8'hB0 + k));
        end

        // R5 R9: read-only entry refuses writes, line untouched
        fill_tlb(6'h2A, 1, 16'h1234, 22'h0ABCD, 1, 0);
        access("R5", 32'h1234ABC5, 1, 8'hEE);
        check("R5", "write perm fault", 32'(s_fault), 1);
        access("R9", 32'h1234ABC5, 0, 0);
        check("R9", "unchanged", 32'(s_rdata), 32'h5A);
        fill_tlb(6'h2A, 1, 16'h1234, 22'h0ABCD, 0, 1);
        access("R5", 32'h1234ABC5, 0, 0);
        check("R5", "read perm fault", 32'(s_fault), 1);
        access("R9", 32'h1234ABE3, 1, 8'h77);
        fill_tlb(6'h2A, 1, 16'h1234, 22'h0ABCD, 1, 1);

        // R11: fill and write hit on same line in one cycle, fill wins
        req_valid = 1; req_va = 32'h1234ABC2; req_write = 1; req_wdata = 8'h99;
        line_fill_en = 1; line_fill_idx = 6'h3C; line_fill_valid = 1;
        line_fill_ptag = 22'h0ABCD; line_fill_data = mk_line(8'h40);
        cycle("R11");
        access("R11", 32'h1234ABC2, 0, 0);
        check("R11", "fill wins", 32'(s_rdata), 32'h42);

        // R2: invalidating the entry makes it fault
        fill_tlb(6'h2A, 0, 16'h1234, 22'h0ABCD, 1, 1);
        access("R2", 32'h1234ABC2, 0, 0);
        check("R2", "invalidated", 32'(s_fault), 1);

        // Mixed traffic against the model over a small address pool
        for (int n = 0; n < 600; n++) begin
            bit [5:0]  ti = ($urandom % 2) ? 6'h2A : 6'h05;
            bit [5:0]  li = ($urandom % 2) ? 6'h3C : 6'h01;
            bit [15:0] tg = ($urandom % 2) ? 16'h1234 : 16'h00FF;
            bit [21:0] pf = ($urandom % 2) ? 22'h0ABCD : 22'h00077;
            int        r  = $urandom % 10;
            if (r == 0) begin
                tlb_fill_en = 1; tlb_fill_idx = ti; tlb_fill_valid = ($urandom % 4) != 0;
                tlb_fill_tag = tg; tlb_fill_pfn = pf;
                tlb_fill_rd = $urandom % 2; tlb_fill_wr = $urandom % 2;
            end else if (r == 1) begin
                line_fill_en = 1; line_fill_idx = li; line_fill_valid = ($urandom % 4) != 0;
                line_fill_ptag = pf; line_fill_data = mk_line(8'($urandom));
            end
            req_valid = ($urandom % 8) != 0;
            req_va = {tg, ti, li, 4'($urandom)};
            req_write = $urandom % 2;
            req_wdata = 8'($urandom);
            cycle((n % 2) ? "R3" : "R8");
        end

        // R10: reset mid-run invalidates everything
        rst = 1;
        cycle("R10");
        rst = 0;
        access("R10", 32'h1234ABCD, 0, 0);
        check("R10", "fault after mid reset", 32'(s_fault), 1);

        finish_run();
    end

endmodule